// File: doc/BRIEF.md
# Zero-Suppressed Event Memory Controller

This block sits behind a 64-channel discriminator front end and captures events into a small store of `NSLOT` slots. Each trigger strobe records the bunch-crossing counter value present that cycle together with the pattern of channels that fired. At readout, only the fired channels are turned into output words. Channels that stayed quiet cost nothing in the output stream. A trigger in which every channel fires is treated as noise and leaves no trace.

Two configuration pins set the policy. `cfg_roll` low keeps the earliest `NSLOT` events and ignores triggers once the store is full. `cfg_roll` high turns the store into a ring that always holds the newest `NSLOT` events. `cfg_always_id` decides whether a readout request on an empty store produces nothing, or a single chip-ID word.

The readout is a valid/ready word stream toward a serializer. Once `out_valid` is high, the word and its `out_last` flag stay fixed until `out_ready` is seen high on a rising edge. The consumer may hold `out_ready` low for any number of cycles. A word is transferred on each edge where both signals are high. The store empties on the edge that transfers the word marked `out_last`.

Top module: `zs_event_mem`

## Requirements
- R1: Every channel set in a stored event produces exactly one hit word `{2'b01, 8'b0, ch[5:0]}`, in ascending channel order. Channels that are clear produce no word.
- R2: Each stored event begins with an event word `{2'b10, 2'b00, bcid[11:0]}`, where `bcid` is the value present in the cycle the trigger was accepted.
- R3: Every readout starts with the chip-ID word `{2'b11, 6'b0, chip_id[7:0]}`. The stored events then follow, oldest first, in arrival order.
- R4: With `cfg_roll`=0, once `NSLOT` events are stored, further triggers are ignored and the first `NSLOT` events are read out.
- R5: With `cfg_roll`=1, a trigger on a full store replaces the oldest event, so the newest `NSLOT` events are read out.
- R6: A trigger whose hit vector has all `NCH` bits set stores nothing.
- R7: With `cfg_always_id`=0, a readout request on an empty store produces no word at all.
- R8: With `cfg_always_id`=1, a readout request on an empty store produces one chip-ID word, with `out_last` high.
- R9: `out_last` marks the final word of a readout. After that word is transferred, the store is empty, and the next readout shows only triggers accepted afterwards.
- R10: A trigger is ignored while a readout is in progress, and also in the cycle in which `rd_req` is accepted. A `rd_req` that arrives during a readout is ignored.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values on the next cycle.
- R12: A stored event with no channel set is read out as its event word alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_roll | input | 1 | 1: ring keeping the newest events; 0: keep the first events |
| cfg_always_id | input | 1 | 1: an empty readout still sends the chip-ID word |
| chip_id | input | ID_W | Identifier placed in the header word |
| trig | input | 1 | Trigger strobe, one cycle per event |
| hit_vec | input | NCH | Fired channels for this trigger |
| bcid | input | BCID_W | Bunch-crossing counter value |
| rd_req | input | 1 | Readout request pulse |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 16 | Output word |
| out_last | output | 1 | Final word of this readout |

## Verification
The stored-event count is swept from zero to past the slot depth, with the hit patterns generated arithmetically:
- Two-channel masks show that quiet channels are suppressed and that ordering is ascending.
- Masks including channels 0 and 63 cover the edges of the priority scan.
- Empty masks separate a zero-hit event from a lost event.

Each sweep is run under both storage modes and both empty-readout policies, so that overflow discards the newest events in one mode and the oldest in the other. Some runs insert an all-ones trigger, which would show up as an extra event if the noise veto failed. Other runs inject triggers and repeated requests in mid-stream, which would show up as extra words in the follow-up readout. Throttled ready patterns check that words are held under back-pressure.

// File: rtl/zs_pkg.sv
package zs_pkg;
  localparam int WORD_W = 16;
  localparam logic [1:0] TAG_ID  = 2'b11;
  localparam logic [1:0] TAG_EVT = 2'b10;
  localparam logic [1:0] TAG_HIT = 2'b01;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_ID,
    RD_EVT,
    RD_HIT
  } rd_state_e;
endpackage

// File: rtl/zs_slot_mem.sv
module zs_slot_mem #(
  parameter int NSLOT  = 4,
  parameter int NCH    = 64,
  parameter int BCID_W = 12,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [NCH-1:0]    wr_mask,
  input  logic [BCID_W-1:0] wr_bcid,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [NCH-1:0]    rd_mask,
  output logic [BCID_W-1:0] rd_bcid
);
  logic [NCH-1:0]    mask_q [NSLOT];
  logic [BCID_W-1:0] bcid_q [NSLOT];

  // One register pair per slot; only the addressed slot loads.
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[s] <= '0;
        bcid_q[s] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(s))) begin
        mask_q[s] <= wr_mask;
        bcid_q[s] <= wr_bcid;
      end
    end
  end

  assign rd_mask = mask_q[rd_idx];
  assign rd_bcid = bcid_q[rd_idx];
endmodule

// File: rtl/zs_ring_ctrl.sv
module zs_ring_ctrl #(
  parameter int NSLOT = 4,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CNT_W = $clog2(NSLOT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             roll,
  input  logic             clear,
  output logic [IDX_W-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_go
);
  localparam int SUM_W = IDX_W + CNT_W + 1;

  logic             full;
  logic [SUM_W-1:0] tail_sum;
  logic [SUM_W-1:0] head_inc;

  assign full     = (count == CNT_W'(NSLOT));
  assign tail_sum = SUM_W'(head) + SUM_W'(count);
  assign head_inc = SUM_W'(head) + SUM_W'(1);

  // Slot after the newest event; equals head when the ring is full.
  assign wr_idx = (tail_sum >= SUM_W'(NSLOT)) ? IDX_W'(tail_sum - SUM_W'(NSLOT))
                                              : IDX_W'(tail_sum);
  // A full store takes a new event only in ring mode.
  assign wr_go  = push && (!full || roll);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      count <= '0;
    end else if (clear) begin
      head  <= '0;
      count <= '0;
    end else if (wr_go) begin
      if (full) begin
        head <= (head_inc >= SUM_W'(NSLOT)) ? '0 : IDX_W'(head_inc);
      end else begin
        count <= count + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/zs_hit_scan.sv
module zs_hit_scan #(
  parameter int NCH = 64,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]  rem,
  output logic            any,
  output logic [CH_W-1:0] first,
  output logic            single
);
  // Lowest set channel wins.
  always_comb begin
    first = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (rem[i]) first = CH_W'(i);
    end
  end

  assign any    = |rem;
  assign single = any && ((rem & (rem - NCH'(1))) == '0);
endmodule

// File: rtl/zs_readout_fsm.sv
module zs_readout_fsm
  import zs_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int NCH    = 64,
  parameter int BCID_W = 12,
  parameter int ID_W   = 8,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CNT_W = $clog2(NSLOT + 1),
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              always_id,
  input  logic [ID_W-1:0]   chip_id,
  input  logic [IDX_W-1:0]  head,
  input  logic [CNT_W-1:0]  count,
  input  logic [NCH-1:0]    slot_mask,
  input  logic [BCID_W-1:0] slot_bcid,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              busy,
  output logic              clear
);
  localparam int SUM_W = IDX_W + CNT_W + 1;

  rd_state_e        state;
  logic [CNT_W-1:0] ev;
  logic [NCH-1:0]   rem;
  logic             any_hit;
  logic [CH_W-1:0]  first_ch;
  logic             one_left;
  logic             fire;
  logic             last_evt;
  logic [SUM_W-1:0] idx_sum;

  zs_hit_scan #(.NCH(NCH)) u_scan (
    .rem    (rem),
    .any    (any_hit),
    .first  (first_ch),
    .single (one_left)
  );

  // Slot being read: oldest event plus the event offset, wrapped.
  assign idx_sum  = SUM_W'(head) + SUM_W'(ev);
  assign rd_idx   = (idx_sum >= SUM_W'(NSLOT)) ? IDX_W'(idx_sum - SUM_W'(NSLOT))
                                               : IDX_W'(idx_sum);
  assign last_evt = ((CNT_W + 1)'(ev) + (CNT_W + 1)'(1)) == (CNT_W + 1)'(count);
  assign busy     = (state != RD_IDLE);
  assign fire     = out_valid && out_ready;
  assign clear    = fire && out_last;

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    case (state)
      RD_ID: begin
        out_valid              = 1'b1;
        out_data[WORD_W-1 -: 2] = TAG_ID;
        out_data[ID_W-1:0]     = chip_id;
        out_last               = (count == '0);
      end
      RD_EVT: begin
        out_valid              = 1'b1;
        out_data[WORD_W-1 -: 2] = TAG_EVT;
        out_data[BCID_W-1:0]   = slot_bcid;
        out_last               = last_evt && (slot_mask == '0);
      end
      RD_HIT: begin
        out_valid              = 1'b1;
        out_data[WORD_W-1 -: 2] = TAG_HIT;
        out_data[CH_W-1:0]     = first_ch;
        out_last               = last_evt && one_left;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RD_IDLE;
      ev    <= '0;
      rem   <= '0;
    end else begin
      case (state)
        RD_IDLE: begin
          if (start && ((count != '0) || always_id)) state <= RD_ID;
        end
        RD_ID: begin
          if (fire) begin
            ev    <= '0;
            state <= (count == '0) ? RD_IDLE : RD_EVT;
          end
        end
        RD_EVT: begin
          if (fire) begin
            rem <= slot_mask;
            if (slot_mask != '0) begin
              state <= RD_HIT;
            end else if (last_evt) begin
              state <= RD_IDLE;
            end else begin
              ev <= ev + CNT_W'(1);
            end
          end
        end
        RD_HIT: begin
          if (fire) begin
            rem <= rem & ~(NCH'(1) << first_ch);
            if (one_left || !any_hit) begin
              if (last_evt) begin
                state <= RD_IDLE;
              end else begin
                ev    <= ev + CNT_W'(1);
                state <= RD_EVT;
              end
            end
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/zs_event_mem.sv
module zs_event_mem
  import zs_pkg::*;
#(
  parameter int NSLOT     = 4,
  parameter int NCH       = 64,
  parameter int BCID_W    = 12,
  parameter int ID_W      = 8,
  parameter int NOISY_LIM = NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_roll,
  input  logic              cfg_always_id,
  input  logic [ID_W-1:0]   chip_id,
  input  logic              trig,
  input  logic [NCH-1:0]    hit_vec,
  input  logic [BCID_W-1:0] bcid,
  input  logic              rd_req,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [15:0]       out_data,
  output logic              out_last
);
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int CNT_W = $clog2(NSLOT + 1);
  localparam int HC_W  = $clog2(NCH + 1);

  logic [HC_W-1:0]   hit_cnt;
  logic              noisy;
  logic              busy;
  logic              push;
  logic              clear;
  logic              wr_go;
  logic [IDX_W-1:0]  head;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [CNT_W-1:0]  count;
  logic [NCH-1:0]    slot_mask;
  logic [BCID_W-1:0] slot_bcid;

  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < NCH; i++) hit_cnt = hit_cnt + HC_W'(hit_vec[i]);
  end

  assign noisy = (hit_cnt >= HC_W'(NOISY_LIM));
  // Readout owns the store from the accepting cycle until the last word.
  assign push  = trig && !noisy && !busy && !rd_req;

  zs_ring_ctrl #(.NSLOT(NSLOT)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .roll   (cfg_roll),
    .clear  (clear),
    .head   (head),
    .count  (count),
    .wr_idx (wr_idx),
    .wr_go  (wr_go)
  );

  zs_slot_mem #(.NSLOT(NSLOT), .NCH(NCH), .BCID_W(BCID_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_go),
    .wr_idx  (wr_idx),
    .wr_mask (hit_vec),
    .wr_bcid (bcid),
    .rd_idx  (rd_idx),
    .rd_mask (slot_mask),
    .rd_bcid (slot_bcid)
  );

  zs_readout_fsm #(.NSLOT(NSLOT), .NCH(NCH), .BCID_W(BCID_W), .ID_W(ID_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (rd_req),
    .always_id (cfg_always_id),
    .chip_id   (chip_id),
    .head      (head),
    .count     (count),
    .slot_mask (slot_mask),
    .slot_bcid (slot_bcid),
    .rd_idx    (rd_idx),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .busy      (busy),
    .clear     (clear)
  );
endmodule

// File: rtl/zs_event_mem_chk.sv
module zs_event_mem_chk #(
  parameter int NSLOT = 4,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CNT_W = $clog2(NSLOT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_roll,
  input logic             cfg_always_id,
  input logic             trig,
  input logic             rd_req,
  input logic             noisy,
  input logic             busy,
  input logic             out_valid,
  input logic             out_ready,
  input logic [15:0]      out_data,
  input logic             out_last,
  input logic [IDX_W-1:0] head,
  input logic [CNT_W-1:0] count
);
  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(NSLOT));

  assert_noisy_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig && noisy && !busy |=> $stable(count) && $stable(head));

  assert_first_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !cfg_roll && !busy && count == CNT_W'(NSLOT) |=> count == CNT_W'(NSLOT) && $stable(head));

  assert_roll_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig && cfg_roll && !noisy && !busy && !rd_req && count == CNT_W'(NSLOT)
    |=> count == CNT_W'(NSLOT) && !$stable(head));

  assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_empty_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> count == '0);

  assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(out_valid && out_ready && out_last) |=> $stable(count) && $stable(head));

  assert_id_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> out_data[15:14] == 2'b11);

  assert_silent_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && rd_req && count == '0 && !cfg_always_id |=> !out_valid);
endmodule

bind zs_event_mem zs_event_mem_chk #(.NSLOT(NSLOT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_roll      (cfg_roll),
  .cfg_always_id (cfg_always_id),
  .trig          (trig),
  .rd_req        (rd_req),
  .noisy         (noisy),
  .busy          (busy),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .out_last      (out_last),
  .head          (head),
  .count         (count)
);

// File: tb/zs_event_mem_tb.sv
`timescale 1ns/1ps
module zs_event_mem_tb;
  localparam int NSLOT = 4;
  localparam int NCH   = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_roll = 1'b0;
  logic        cfg_always_id = 1'b0;
  logic [7:0]  chip_id = 8'hA5;
  logic        trig = 1'b0;
  logic [63:0] hit_vec = '0;
  logic [11:0] bcid = '0;
  logic        rd_req = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_last;

  int checks = 0;
  int fails  = 0;
  int gk     = 0;

  logic [63:0] mdl_mask[$];
  logic [11:0] mdl_bcid[$];
  logic [16:0] expw[$];
  logic [16:0] got[$];

  always #5 clk = ~clk;

  zs_event_mem u_dut (
    .clk (clk), .rst_n (rst_n), .cfg_roll (cfg_roll), .cfg_always_id (cfg_always_id),
    .chip_id (chip_id), .trig (trig), .hit_vec (hit_vec), .bcid (bcid), .rd_req (rd_req),
    .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data), .out_last (out_last)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mask_for(input int k);
    logic [63:0] m = '0;
    m[(k * 7 + 3) % 64]   = 1'b1;
    m[(k * 13 + 20) % 64] = 1'b1;
    if (k % 3 == 0) begin m[63] = 1'b1; m[0] = 1'b1; end
    if (k % 4 == 2) m = '0;  // zero-hit event, R12
    return m;
  endfunction

  // Trigger issued at a negedge; returns at the next negedge.
  task automatic do_trig(input logic [63:0] m, input logic [11:0] b, input bit model);
    hit_vec = m; bcid = b; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    if (model && m != '1) begin
      if (mdl_mask.size() < NSLOT) begin
        mdl_mask.push_back(m); mdl_bcid.push_back(b);
      end else if (cfg_roll) begin
        void'(mdl_mask.pop_front()); void'(mdl_bcid.pop_front());
        mdl_mask.push_back(m); mdl_bcid.push_back(b);
      end
    end
  endtask

  task automatic build_expected();
    expw.delete();
    if (mdl_mask.size() == 0) begin
      if (cfg_always_id) expw.push_back({1'b1, 2'b11, 6'b0, chip_id});
    end else begin
      expw.push_back({1'b0, 2'b11, 6'b0, chip_id});
      for (int e = 0; e < mdl_mask.size(); e++) begin
        expw.push_back({1'b0, 2'b10, 2'b00, mdl_bcid[e]});
        for (int c = 0; c < NCH; c++)
          if (mdl_mask[e][c]) expw.push_back({1'b0, 2'b01, 8'b0, 6'(c)});
      end
      expw[expw.size() - 1][16] = 1'b1;
    end
    mdl_mask.delete(); mdl_bcid.delete();
  endtask

  task automatic run_readout(input bit throttle, input bit inject, input string tag);
    bit done = 0;
    bit held = 0;
    logic [16:0] prev = '0;
    int limit;
    build_expected();
    limit = (expw.size() == 0) ? 8 : 600;
    got.delete();
    // R10: a trigger in the request cycle must be ignored.
    if (inject) begin trig = 1'b1; hit_vec = 64'h0000_0000_0000_0F00; end
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; trig = 1'b0;
    for (int c = 0; c < limit; c++) begin
      out_ready = throttle ? (c % 3 != 1) : 1'b1;
      trig   = inject && (c == 1);
      rd_req = inject && (c == 2);
      if (trig) hit_vec = 64'h0000_0F0F_0000_0001;
      if (held) check(out_valid && {out_last, out_data} == prev, "R11 held word",
                      {15'b0, out_valid, out_last, out_data}, {15'b0, 1'b1, prev});
      if (out_valid && out_ready) begin
        got.push_back({out_last, out_data});
        if (out_last) done = 1;
      end
      held = out_valid && !out_ready;
      prev = {out_last, out_data};
      @(negedge clk);
      if (done) break;
    end
    trig = 1'b0; rd_req = 1'b0; out_ready = 1'b0;
    check(got.size() == expw.size(), {tag, " R9 word count"}, got.size(), expw.size());
    for (int i = 0; i < expw.size() && i < got.size(); i++) begin
      string wt;
      wt = (expw[i][15:14] == 2'b11) ? " R3 id word" :
           (expw[i][15:14] == 2'b10) ? " R2 event word" : " R1 hit word";
      check(got[i] == expw[i], {tag, wt}, {15'b0, got[i]}, {15'b0, expw[i]});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_last == 1'b0, "R7 reset idle", {31'b0, out_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int r = 0; r < 2; r++) begin
      for (int a = 0; a < 2; a++) begin
        for (int n = 0; n <= 6; n++) begin
          string tg;
          cfg_roll = r[0]; cfg_always_id = a[0];
          tg = (n == 0) ? (a ? "R8" : "R7") : (n > NSLOT) ? (r ? "R5" : "R4") : "R12";
          for (int k = 0; k < n; k++) begin
            if (n >= 3 && k == 1) do_trig('1, 12'hFFF, 1'b1);  // R6 noisy
            do_trig(mask_for(gk), 12'((gk * 37 + 5) % 4096), 1'b1);
            gk++;
          end
          run_readout(r[0] ^ a[0], n[0], n >= 3 ? {tg, " R6"} : tg);
          // R9/R10: store emptied, injected triggers absent.
          run_readout(a[0], 1'b0, a ? "R8 R10 after" : "R7 R10 after");
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule